// File: doc/BRIEF.md
# Ping-Pong Buffered Raw Bit Serializer

This block sends 32-bit words from memory onto a single output line exactly as stored. It adds no line coding and no parity, so software decides the level of every bit cell. Each word leaves one bit per pulse of an external clock enable. A configuration input chooses whether bit 0 or bit 31 of a word goes out first.

Words come from two buffers in memory. Software describes each buffer with a base word address and a word count. The block reads the words of one buffer, then moves to the other buffer. When it has read the last word of a buffer, it frees that descriptor and raises a one-cycle refill request for it. Software refills the freed descriptor while the other buffer drains. Reading uses a simple request/response port with one read outstanding at a time. The next word is read into a holding register well before the current word ends, so words and buffers follow each other with no gap.

If the line needs a word and the buffer to be read next is empty, the line holds its level and a sticky underrun flag is set. Clearing the enable lets the current word finish and then drives the line low.

Top module: `pp_bit_serializer`

## Requirements
- R1: While rst_ni is low, and after reset until stimulus arrives, ser_o, mem_req_o, buf_full_o, buf_irq_o and underrun_o are all 0. Fetching starts with buffer 0.
- R2: Each word is sent unchanged, one bit per clock edge at which bit_tick_i is high. When msb_first_i is 0, word bit 0 goes first and bit 31 last. When msb_first_i is 1, bit 31 goes first and bit 0 last. ser_o changes only at edges where bit_tick_i is high.
- R3: A cycle with buf_wr_i high loads buf_base_i and buf_len_i into the descriptor chosen by buf_sel_i (0 or 1) and sets that buffer's bit in buf_full_o. The bit is buf_full_o[0] for buffer 0 and buf_full_o[1] for buffer 1. The count must be at least 1.
- R4: A buffer's words are read at word addresses base, base+1, and so on, for count words. At most one read is outstanding. A read is requested only while en_i is high and a buffer is marked full.
- R5: When the last word of a buffer has been read, that buffer's full bit clears and its bit of buf_irq_o is high for exactly one cycle. Fetching then continues from the other buffer.
- R6: When the read latency is well below one word time, successive words and words across a buffer switch leave the line with no gap. A new bit is sent at every tick.
- R7: Suppose that at a word boundary tick no word is ready and the buffer to be read next is not full. Then ser_o keeps its last level and underrun_o is set and stays set. Once that buffer is filled, sending resumes at a later boundary tick.
- R8: underrun_o is cleared at the first clock edge at which en_i is seen high after being low.
- R9: After en_i falls, the word in progress still completes. Later boundary ticks drive ser_o low. No read is issued while disabled. A word that was already prefetched is kept and is the first word sent after re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmit enable |
| msb_first_i | input | 1 | 1: bit 31 first, 0: bit 0 first |
| bit_tick_i | input | 1 | Bit clock enable |
| buf_wr_i | input | 1 | Descriptor write strobe |
| buf_sel_i | input | 1 | Descriptor to write |
| buf_base_i | input | ADDR_W | Base word address |
| buf_len_i | input | LEN_W | Word count |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Read word address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | WORD_W | Read data |
| ser_o | output | 1 | Serial line |
| buf_full_o | output | 2 | Buffer descriptors holding data |
| buf_irq_o | output | 2 | One-cycle refill request per buffer |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The memory model answers each read one cycle after mem_req_o, so a prefetched word sits in the holding register two edges after the request. The bench therefore waits four cycles after enabling before it starts the ticks. The first bit of a word appears on ser_o after the first edge that sees a tick at a word boundary. The monitor records bit_tick_i at each rising edge and compares ser_o with the next expected bit at the following falling edge, so no comparison depends on the order of processes at an edge. A refill request shows one cycle after the edge that accepts the buffer's last word. The underrun flag shows one cycle after the failing boundary tick, and it clears one cycle after the enable rises. Both are sampled at the falling edge after those edges, or captured by the monitor at the moment the last expected bit leaves.

// File: rtl/ppser_pkg.sv
package ppser_pkg;
  typedef enum logic {FS_IDLE, FS_WAIT} fetch_state_e;
endpackage

// File: rtl/ppser_desc_regs.sv
module ppser_desc_regs #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic                   sel_i,
  input  logic [ADDR_W-1:0]      base_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [1:0]             done_i,
  output logic [1:0][ADDR_W-1:0] base_o,
  output logic [1:0][LEN_W-1:0]  len_o,
  output logic [1:0]             full_o
);
  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic              full_q;
    logic              hit;
    assign hit = wr_i && (sel_i == 1'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        len_q  <= '0;
        full_q <= 1'b0;
      end else if (hit) begin
        base_q <= base_i;
        len_q  <= len_i;
        full_q <= 1'b1;
      end else if (done_i[b]) begin
        full_q <= 1'b0;
      end
    end
    assign base_o[b] = base_q;
    assign len_o[b]  = len_q;
    assign full_o[b] = full_q;
  end
endmodule

// File: rtl/ppser_fetch.sv
module ppser_fetch
  import ppser_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic [1:0][ADDR_W-1:0] base_i,
  input  logic [1:0][LEN_W-1:0]  len_i,
  input  logic [1:0]             full_i,
  input  logic                   take_i,
  output logic                   mem_req_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  input  logic                   mem_rvalid_i,
  input  logic [WORD_W-1:0]      mem_rdata_i,
  output logic [1:0]             done_o,
  output logic                   cur_full_o,
  output logic                   hold_vld_o,
  output logic [WORD_W-1:0]      hold_o
);
  fetch_state_e      state_q;
  logic              cur_q;
  logic [LEN_W-1:0]  idx_q;
  logic [WORD_W-1:0] hold_q;
  logic              hold_vld_q;
  logic              last_word, accept;

  assign cur_full_o = full_i[cur_q];
  assign mem_req_o  = (state_q == FS_IDLE) && en_i && !hold_vld_q && full_i[cur_q];
  assign mem_addr_o = base_i[cur_q] + ADDR_W'(idx_q);
  assign last_word  = (idx_q == len_i[cur_q] - LEN_W'(1));
  assign accept     = (state_q == FS_WAIT) && mem_rvalid_i;
  assign done_o     = (accept && last_word) ? (cur_q ? 2'b10 : 2'b01) : 2'b00;
  assign hold_vld_o = hold_vld_q;
  assign hold_o     = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= FS_IDLE;
      cur_q      <= 1'b0;
      idx_q      <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else begin
      if (mem_req_o) state_q <= FS_WAIT;
      if (accept) begin
        state_q    <= FS_IDLE;
        hold_q     <= mem_rdata_i;
        hold_vld_q <= 1'b1;
        if (last_word) begin
          idx_q <= '0;
          cur_q <= ~cur_q;
        end else begin
          idx_q <= idx_q + LEN_W'(1);
        end
      end else if (take_i) begin
        hold_vld_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ppser_shifter.sv
module ppser_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              msb_first_i,
  input  logic              tick_i,
  input  logic              hold_vld_i,
  input  logic [WORD_W-1:0] hold_i,
  input  logic              cur_full_i,
  output logic              take_o,
  output logic              starve_o,
  output logic              ser_o
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] word_q;
  logic [CW-1:0]     cnt_q, bidx;
  logic              line_q, boundary;

  assign boundary = (cnt_q == '0);
  assign bidx     = msb_first_i ? (LAST - cnt_q) : cnt_q;
  assign take_o   = tick_i && boundary && en_i && hold_vld_i;
  assign starve_o = tick_i && boundary && en_i && !hold_vld_i && !cur_full_i;
  assign ser_o    = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
      line_q <= 1'b0;
    end else if (tick_i) begin
      if (!boundary) begin
        line_q <= word_q[bidx];
        cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      end else if (take_o) begin
        word_q <= hold_i;
        line_q <= msb_first_i ? hold_i[WORD_W-1] : hold_i[0];
        cnt_q  <= CW'(1);
      end else if (!en_i) begin
        line_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pp_bit_serializer.sv
module pp_bit_serializer #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              msb_first_i,
  input  logic              bit_tick_i,
  input  logic              buf_wr_i,
  input  logic              buf_sel_i,
  input  logic [ADDR_W-1:0] buf_base_i,
  input  logic [LEN_W-1:0]  buf_len_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              ser_o,
  output logic [1:0]        buf_full_o,
  output logic [1:0]        buf_irq_o,
  output logic              underrun_o
);
  logic [1:0][ADDR_W-1:0] base;
  logic [1:0][LEN_W-1:0]  len;
  logic [1:0]             done;
  logic                   take, starve, cur_full, hold_vld;
  logic [WORD_W-1:0]      hold;
  logic                   en_q, under_q;
  logic [1:0]             irq_q;

  ppser_desc_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_desc (
    .clk_i, .rst_ni, .wr_i(buf_wr_i), .sel_i(buf_sel_i), .base_i(buf_base_i),
    .len_i(buf_len_i), .done_i(done), .base_o(base), .len_o(len), .full_o(buf_full_o)
  );

  ppser_fetch #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_fetch (
    .clk_i, .rst_ni, .en_i, .base_i(base), .len_i(len), .full_i(buf_full_o),
    .take_i(take), .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .done_o(done), .cur_full_o(cur_full), .hold_vld_o(hold_vld), .hold_o(hold)
  );

  ppser_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk_i, .rst_ni, .en_i, .msb_first_i, .tick_i(bit_tick_i),
    .hold_vld_i(hold_vld), .hold_i(hold), .cur_full_i(cur_full),
    .take_o(take), .starve_o(starve), .ser_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      under_q <= 1'b0;
      irq_q   <= '0;
    end else begin
      en_q  <= en_i;
      irq_q <= done;
      if (en_i && !en_q) under_q <= 1'b0;
      else if (starve)   under_q <= 1'b1;
    end
  end

  assign buf_irq_o  = irq_q;
  assign underrun_o = under_q;
endmodule

// File: rtl/ppser_checker.sv
module ppser_checker #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              bit_tick_i,
  input logic              buf_wr_i,
  input logic              buf_sel_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_rdata_i,
  input logic              ser_o,
  input logic [1:0]        buf_full_o,
  input logic [1:0]        buf_irq_o,
  input logic              underrun_o
);
  AST_LINE_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(ser_o)); // R2
  AST_ONE_READ_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R4
  AST_READ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> en_i && (buf_full_o != 2'b00)); // R4
  AST_IRQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(buf_irq_o)); // R5
  AST_IRQ0_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_irq_o[0] && !$past(buf_wr_i && !buf_sel_i) |-> !buf_full_o[0]); // R5
  AST_IRQ1_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_irq_o[1] && !$past(buf_wr_i && buf_sel_i) |-> !buf_full_o[1]); // R5
  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(underrun_o) && !underrun_o |-> $past(en_i) && !$past(en_i, 2)); // R8
endmodule

bind pp_bit_serializer ppser_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_ppser_checker (
  .clk_i, .rst_ni, .en_i, .bit_tick_i, .buf_wr_i, .buf_sel_i, .mem_req_o, .mem_addr_o,
  .mem_rdata_i, .ser_o, .buf_full_o, .buf_irq_o, .underrun_o
);

// File: tb/test_pp_bit_serializer.sv
`timescale 1ns/1ps
module test_pp_bit_serializer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0, msb = 1'b0, tick = 1'b0;
  logic        wr = 1'b0, sel = 1'b0;
  logic [15:0] base = '0;
  logic [11:0] len = '0;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        ser, underrun;
  logic [1:0]  full, irq;

  int tests = 0, fails = 0;
  int irq0_cnt = 0, irq1_cnt = 0;
  logic tick_seen = 1'b0;
  logic under_at_drain = 1'b0;
  logic exp_q[$];
  logic [15:0] addr_q[$];

  always #5 clk = ~clk;

  pp_bit_serializer i_pp_bit_serializer (
    .clk_i(clk), .rst_ni, .en_i(en), .msb_first_i(msb), .bit_tick_i(tick),
    .buf_wr_i(wr), .buf_sel_i(sel), .buf_base_i(base), .buf_len_i(len),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .ser_o(ser), .buf_full_o(full), .buf_irq_o(irq),
    .underrun_o(underrun)
  );

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    return {a ^ 16'hC3A5, ~a} ^ 32'h1F2E_3D4C;
  endfunction

  // one-cycle memory
  always @(posedge clk) begin
    mem_rvalid <= mem_req && rst_ni;
    mem_rdata  <= mem_word(mem_addr);
    tick_seen  <= tick;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for bits, addresses and refill requests
  always @(negedge clk) begin
    if (!rst_ni) begin
      irq0_cnt = 0;
      irq1_cnt = 0;
    end else begin
      if (irq[0]) irq0_cnt++;
      if (irq[1]) irq1_cnt++;
      if (mem_req) begin
        if (addr_q.size() == 0) check("R4 R9 unexpected read", {16'h0, mem_addr}, 32'hFFFF);
        else check("R4 read address", {16'h0, mem_addr}, {16'h0, addr_q.pop_front()});
      end
      if (tick_seen && exp_q.size() > 0) begin
        check("R2 R6 serial bit", {31'h0, ser}, {31'h0, exp_q.pop_front()});
        if (exp_q.size() == 0) under_at_drain = underrun;
      end
    end
  end

  task automatic push_word(input logic [15:0] a, input logic m);
    logic [31:0] w = mem_word(a);
    for (int i = 0; i < 32; i++) exp_q.push_back(m ? w[31-i] : w[i]);
  endtask

  task automatic set_buf(input logic s, input logic [15:0] b, input logic [11:0] n);
    @(negedge clk);
    wr = 1'b1; sel = s; base = b; len = n;
    for (int i = 0; i < int'(n); i++) addr_q.push_back(b + 16'(i));
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; en = 1'b0; tick = 1'b0; wr = 1'b0; msb = 1'b0;
    exp_q.delete(); addr_q.delete();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic held;
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 ser", {31'h0, ser}, 0);
    check("R1 req", {31'h0, mem_req}, 0);
    check("R1 full", {30'h0, full}, 0);
    check("R1 irq", {30'h0, irq}, 0);
    check("R1 underrun", {31'h0, underrun}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle ser", {31'h0, ser}, 0);

    // A: LSB first, refill during run, back-to-back buffers
    set_buf(1'b0, 16'h0000, 12'd3);
    check("R3 full0 set", {30'h0, full}, 2'b01);
    set_buf(1'b1, 16'h0020, 12'd2);
    check("R3 both full", {30'h0, full}, 2'b11);
    en = 1'b1;
    push_word(16'h0000, 0); push_word(16'h0001, 0); push_word(16'h0002, 0);
    push_word(16'h0020, 0); push_word(16'h0021, 0);
    push_word(16'h0010, 0); push_word(16'h0011, 0);
    repeat (4) @(negedge clk);
    tick = 1'b1;
    while (irq0_cnt == 0) @(negedge clk);
    check("R5 full0 cleared", {31'h0, full[0]}, 0);
    set_buf(1'b0, 16'h0010, 12'd2);
    drain();
    check("R6 no underrun across switches", {31'h0, under_at_drain}, 0);
    check("R5 irq0 count", irq0_cnt, 2);
    check("R5 irq1 count", irq1_cnt, 1);
    check("R5 all freed", {30'h0, full}, 0);

    // B: underrun, hold, resume, sticky, clear on enable rise
    do_reset();
    set_buf(1'b0, 16'h0040, 12'd2);
    en = 1'b1;
    push_word(16'h0040, 0); push_word(16'h0041, 0);
    repeat (4) @(negedge clk);
    tick = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    held = mem_word(16'h0041) >> 31;
    check("R7 line held", {31'h0, ser}, {31'h0, held});
    check("R7 underrun set", {31'h0, underrun}, 1);
    check("R5 single irq0", irq0_cnt, 1);
    repeat (5) @(negedge clk);
    check("R7 still held", {31'h0, ser}, {31'h0, held});
    tick = 1'b0;
    set_buf(1'b1, 16'h0080, 12'd1);
    push_word(16'h0080, 0);
    repeat (4) @(negedge clk);
    tick = 1'b1;
    drain();
    check("R7 resumed, flag sticky", {31'h0, underrun}, 1);
    tick = 1'b0; en = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 kept while disabled", {31'h0, underrun}, 1);
    en = 1'b1;
    @(negedge clk);
    check("R8 cleared on enable", {31'h0, underrun}, 0);

    // C: MSB first, disable mid-word, prefetched word kept
    do_reset();
    msb = 1'b1;
    set_buf(1'b0, 16'h0008, 12'd2);
    set_buf(1'b1, 16'h0030, 12'd1);
    en = 1'b1;
    push_word(16'h0008, 1);
    repeat (4) @(negedge clk);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 8; i++) exp_q.push_back(1'b0);
    drain();
    tick = 1'b0;
    @(negedge clk);
    check("R9 line low", {31'h0, ser}, 0);
    check("R9 buf1 untouched", {30'h0, full}, 2'b10);
    check("R9 no read while off", addr_q.size(), 1);
    en = 1'b1;
    push_word(16'h0009, 1); push_word(16'h0030, 1);
    repeat (2) @(negedge clk);
    tick = 1'b1;
    drain();
    check("R9 resumed with prefetched word", irq1_cnt, 1);
    check("R5 freed after resume", {30'h0, full}, 0);
    tick = 1'b0;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule